// File: doc/BRIEF.md
# Dual-Source Up/Down Event Counter

This block keeps an 8-bit count that moves by one on every step event and drives it straight out to a row of eight indicator lamps. A step event is a single-cycle enable. It comes from one of two places. The first is the rising edge of a push button, which is sampled into the clock domain before the edge is found. The second is a free-running divider that pulses about once or twice per second. A select input picks the source.

A direction switch sets which way each step moves the count. The step enable and the direction are merged into a separate up line and down line, and these form a two-bit mode for the counting core. Only the mode values "up only" and "down only" change the count. "Neither" and "both" hold it. A synchronous, active-low reset returns the count to zero. Debouncing and display decoding are outside this block.

Top module: `evc_top`

## Requirements
- R1: The output `count_o` is 8 bits wide. On any clock edge where `rst_n` is low, the count is cleared to 0.
- R2: Reset wins over a step enable that arrives on the same clock edge, so the count is 0 after that edge.
- R3: With `auto_sel` = 0, each rising edge of `step_btn` produces exactly one step after the synchronizer. This holds however long the button stays high.
- R4: With `auto_sel` = 1, the internal tick is the step source. It produces one step every `TICK_DIV` clock cycles, so a window of n·`TICK_DIV` cycles gives exactly n steps.
- R5: A step with `dir_sw` = 1 adds one to the count. A step with `dir_sw` = 0 subtracts one.
- R6: Adding one to 255 gives 0.
- R7: Subtracting one from 0 gives 255.
- R8: The core mode is {up, dn}. Mode 2'b10 increments, mode 2'b01 decrements, and modes 2'b00 and 2'b11 hold the count. The count therefore changes only on edges where the step enable is high.
- R9: The source that is not selected has no effect. The tick does nothing while `auto_sel` = 0, and button presses do nothing while `auto_sel` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (push button) |
| step_btn | input | 1 | Asynchronous step push button |
| auto_sel | input | 1 | 1 selects the internal tick, 0 selects the button |
| dir_sw | input | 1 | 1 counts up, 0 counts down |
| count_o | output | 8 | Current count, shown directly on the lamps |

## Verification
The hardest case to reach from the ports is a reset that falls on the exact edge where a button step reaches the core. The button passes through the synchronizer and the edge flop, so that edge is hidden behind several cycles of latency. The bench gives a one-cycle button pulse and lowers `rst_n` for only the edge that follows the synchronizer latency. It then checks that the count is 0 and that no second step appears.

Auto-mode windows are held open for whole multiples of the divider period, with presses injected inside them. This gives a step total that is exact whatever the tick phase. Random sequences of presses, windows and resets are then checked against a bench model of the count.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned CNT_W = 8;
  typedef logic [CNT_W-1:0] count_t;

  typedef enum logic [1:0] {
    MODE_HOLD   = 2'b00,
    MODE_DEC    = 2'b01,
    MODE_INC    = 2'b10,
    MODE_FREEZE = 2'b11
  } mode_e;

  // Next count for a given mode; wraps naturally in CNT_W bits.
  function automatic count_t evc_next(input count_t cur, input mode_e m);
    case (m)
      MODE_INC: return cur + count_t'(1);
      MODE_DEC: return cur - count_t'(1);
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/evc_sync_edge.sv
module evc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/evc_tick_gen.sv
module evc_tick_gen #(
  parameter int unsigned TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_DIV - 1);

  logic [TW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + TW'(1);
  end
endmodule

// File: rtl/evc_updn_core.sv
module evc_updn_core
  import evc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   up_req,
  input  logic   dn_req,
  output mode_e  mode_o,
  output count_t count_o
);
  count_t cnt_q;

  assign mode_o  = mode_e'({up_req, dn_req});
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= evc_next(cnt_q, mode_o);
  end
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 100_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_btn,
  input  logic             auto_sel,
  input  logic             dir_sw,
  output logic [CNT_W-1:0] count_o
);
  logic  btn_rise;
  logic  tick;
  logic  step_en;
  logic  up_req;
  logic  dn_req;
  mode_e mode;

  evc_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(step_btn), .rise_o(btn_rise)
  );

  evc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  assign step_en = auto_sel ? tick : btn_rise;
  assign up_req  = step_en &  dir_sw;
  assign dn_req  = step_en & ~dir_sw;

  evc_updn_core u_core (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
    .mode_o(mode), .count_o(count_o)
  );
endmodule

// File: rtl/evc_checker.sv
module evc_checker
  import evc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input logic             btn_rise,
  input logic             tick,
  input mode_e            mode,
  input logic [CNT_W-1:0] count_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> count_o == '0);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> count_o == $past(count_o));

  // R5 R6
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_INC |=> count_o == CNT_W'($past(count_o) + 1'b1));

  // R5 R7
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_DEC |=> count_o == CNT_W'($past(count_o) - 1'b1));

  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> !btn_rise);

  // R4
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind evc_top evc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .btn_rise(btn_rise),
  .tick(tick), .mode(mode), .count_o(count_o)
);

// File: tb/evc_top_tb.sv
module evc_top_tb_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_btn = 1'b0;
  logic       auto_sel = 1'b0;
  logic       dir_sw = 1'b1;
  logic [7:0] count_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_cnt = 8'd0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evc_top #(.SYNC_STAGES(2), .TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_btn(step_btn), .auto_sel(auto_sel),
    .dir_sw(dir_sw), .count_o(count_o)
  );

  // Bench model: mode {up,dn}; 10 +1, 01 -1, else hold, 8-bit wrap.
  function automatic logic [7:0] model_step(logic [7:0] c, logic up, logic dn);
    if (up && !dn) return (c == 8'hFF) ? 8'h00 : c + 8'd1;
    if (dn && !up) return (c == 8'h00) ? 8'hFF : c - 8'd1;
    return c;
  endfunction

  task automatic check(string req, logic [7:0] exp);
    checks++;
    if (count_o !== exp) begin
      failures++;
      $display("FAIL %s count=%0d expected=%0d", req, count_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 8'd0;
  endtask

  task automatic press(logic dir, int hold);
    dir_sw = dir;
    @(negedge clk) step_btn = 1'b1;
    repeat (hold) @(negedge clk);
    step_btn = 1'b0;
    repeat (5) @(negedge clk);
    exp_cnt = model_step(exp_cnt, dir, !dir);
  endtask

  // Auto window of n*DIV edges, with an ignored press inside it.
  task automatic auto_window(logic dir, int n, bit with_press);
    dir_sw = dir;
    @(negedge clk) auto_sel = 1'b1;
    if (with_press) step_btn = 1'b1;
    for (int k = 0; k < n * DIV; k++) begin
      @(negedge clk);
      if (k == 2) step_btn = 1'b0;
    end
    auto_sel = 1'b0;
    step_btn = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) exp_cnt = model_step(exp_cnt, dir, !dir);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset value", 8'd0);

    // R7: down from zero wraps to 255
    press(1'b0, 3);
    check("R7 wrap down", exp_cnt);
    // R6: up from 255 wraps to 0
    press(1'b1, 3);
    check("R6 wrap up", exp_cnt);

    // R3: long hold yields one step
    press(1'b1, 40);
    check("R3 long hold single step", exp_cnt);
    press(1'b1, 1);
    check("R5 up step", exp_cnt);
    press(1'b0, 2);
    check("R5 down step", exp_cnt);

    // R8 R9: idle with button source, ticks fire but do nothing
    repeat (5 * DIV) @(negedge clk);
    check("R9 tick ignored when auto_sel=0 / R8 hold", exp_cnt);

    // R4 R9: auto window with press ignored
    auto_window(1'b1, 3, 1'b1);
    check("R4 auto up three ticks, R9 press ignored", exp_cnt);
    auto_window(1'b0, 2, 1'b0);
    check("R4 auto down two ticks", exp_cnt);

    // R2: reset on the same edge as a button step
    press(1'b1, 3);
    check("R5 pre-reset step", exp_cnt);
    dir_sw = 1'b1;
    @(negedge clk) step_btn = 1'b1;
    @(negedge clk) step_btn = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    exp_cnt = 8'd0;
    repeat (6) @(negedge clk);
    check("R2 reset beats step", exp_cnt);

    // R1: reset from nonzero value
    press(1'b0, 2);
    do_reset();
    @(negedge clk);
    check("R1 reset clears", exp_cnt);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int unsigned op;
      logic d;
      op = $urandom_range(0, 9);
      d  = 1'($urandom_range(0, 1));
      if (op < 6) begin
        press(d, $urandom_range(1, 12));
        check("R3 R5 random press", exp_cnt);
      end else if (op < 9) begin
        auto_window(d, $urandom_range(1, 4), 1'($urandom_range(0, 1)));
        check("R4 R9 random auto window", exp_cnt);
      end else begin
        do_reset();
        @(negedge clk);
        check("R1 random reset", exp_cnt);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule